// File: doc/BRIEF.md
# Register Post-Update Decoder

This block takes the 4-bit auto-update field of an extended instruction and applies the post-increments or post-decrements it asks for. The field can touch up to three register operand fields: the destination, the second source and the short-source field. Alternatively it can touch the condition-register field on its own. For each named field the block works out which physical register really moves, and by how much. A memory-data register is redirected to its paired address register and steps by the access size. An address register named directly steps by the datapath width in bytes. A general register steps by one.

The block holds a small register file model. All post-updates and the instruction's own result land in it together, on one commit strobe, after the operands have been read. The register index space has 16 entries with fixed classes:
- indices 0..7 are general registers;
- indices 8..11 are address registers A0..A3;
- indices 12..15 are memory-data registers D0..D3.

Data register Dk is paired with address register Ak, so index 12+k redirects to index 8+k. A combinational read port exposes every entry.

Top module: `postupd_unit`

## Requirements
- R1: In either form, an update code that selects nothing (code 0000 in register form, low bits 00 in immediate form) changes no entry at commit other than the result write to the destination, when `res_we` is set.
- R2: In register form (`imm_form`=0), `upd_code` selects the updates as follows, where D is destination, S is second source, I is short source and C is condition:
  - 0000: none
  - 0001: S+ I+ D+
  - 0010: I−
  - 0011: I+
  - 0100: S− I−
  - 0101: S+ I+
  - 0110: S−
  - 0111: S+
  - 1000: D− I−
  - 1001: D+ I+
  - 1010: D−
  - 1011: D+
  - 1100: D− S−
  - 1101: D+ S+
  - 1110: C−
  - 1111: C+
- R3: In immediate form (`imm_form`=1), only `upd_code[1:0]` is decoded: 00 none, 01 S+, 10 D+, 11 C−. Bits [3:2] are ignored, and the short-source register is never updated.
- R4: A general register (index 0..7) steps by 1.
- R5: An address register named directly (index 8..11) steps by 4 when `wide32`=1 and by 2 when `wide32`=0.
- R6: A data register (index 12+k) redirects its update to index 8+k. The step is 1, 2 or 4 for `acc_size` 00, 01 and 10 (11 is taken as 4), and the data entry itself is left unchanged.
- R7: When several named fields resolve to the same physical register, each naming adds its own step, and the total is written once.
- R8: When an update targets the destination that is also written with `res_data`, the step is applied to the new result value.
- R9: Every written value wraps modulo the datapath: with `wide32`=0, only the low 16 bits are kept and the upper bits are zero.
- R10: No entry changes in a cycle without `commit`, and all writes of one instruction appear on the same clock edge.
- R11: Asynchronous reset (`rst_n` low) clears every entry to zero.
- R12: One instruction never mixes increment and decrement. A condition update never comes with any other update, and the immediate form updates at most one register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| commit | input | 1 | Instruction completes: apply result and post-updates |
| imm_form | input | 1 | 1 = immediate form, 0 = three-register form |
| upd_code | input | 4 | Auto-update field |
| dst_idx | input | 4 | Destination register index |
| snd_idx | input | 4 | Second source register index |
| si4_idx | input | 4 | Short-source register index |
| cnd_idx | input | 4 | Condition register index |
| acc_size | input | 2 | Memory access size code (00=1, 01=2, 10/11=4 bytes) |
| wide32 | input | 1 | 1 = 32-bit datapath, 0 = 16-bit datapath |
| res_we | input | 1 | Write `res_data` to the destination at commit |
| res_data | input | 32 | Instruction result |
| rd_idx | input | 4 | Read port index |
| rd_data | output | 32 | Content of entry `rd_idx` |

## Verification
The hardest case to reach is several namings collapsing onto one physical register. One variant has a data register and its own paired address register named in the same instruction. Another has a result write landing on a register that is also being stepped. In both, the write must be a single summed value and not the last step alone. The stimulus loads known bases through result writes with code 0000. It then issues a triple increment with destination D0, second source A0 and a general short source, and a triple increment that names one general register in all three fields. It also issues a destination step with the result write enabled, including 16-bit wrap cases where a large result collapses to zero.

// File: rtl/pu_pkg.sv
package pu_pkg;
  // per-field update selection, bit order is used for field indexing
  typedef struct packed {
    logic cnd;
    logic si4;
    logic snd;
    logic dst;
  } fsel_t;

  localparam int unsigned N_FIELDS = 4;
  localparam int unsigned F_DST = 0;
  localparam int unsigned F_SND = 1;
  localparam int unsigned F_SI4 = 2;
  localparam int unsigned F_CND = 3;
  localparam int unsigned STEP_W = 3;
endpackage

// File: rtl/pu_decode.sv
module pu_decode
  import pu_pkg::*;
(
  input  logic       imm_form,
  input  logic [3:0] upd_code,
  output fsel_t      sel,
  output logic       dec
);
  always_comb begin
    sel = '0;
    dec = 1'b0;
    if (imm_form) begin
      // upper two bits belong to the immediate
      unique case (upd_code[1:0])
        2'b00: ;
        2'b01: sel.snd = 1'b1;
        2'b10: sel.dst = 1'b1;
        default: begin sel.cnd = 1'b1; dec = 1'b1; end
      endcase
    end else begin
      unique case (upd_code)
        4'h0: ;
        4'h1: begin sel.snd = 1'b1; sel.si4 = 1'b1; sel.dst = 1'b1; end
        4'h2: begin sel.si4 = 1'b1; dec = 1'b1; end
        4'h3: sel.si4 = 1'b1;
        4'h4: begin sel.snd = 1'b1; sel.si4 = 1'b1; dec = 1'b1; end
        4'h5: begin sel.snd = 1'b1; sel.si4 = 1'b1; end
        4'h6: begin sel.snd = 1'b1; dec = 1'b1; end
        4'h7: sel.snd = 1'b1;
        4'h8: begin sel.dst = 1'b1; sel.si4 = 1'b1; dec = 1'b1; end
        4'h9: begin sel.dst = 1'b1; sel.si4 = 1'b1; end
        4'hA: begin sel.dst = 1'b1; dec = 1'b1; end
        4'hB: sel.dst = 1'b1;
        4'hC: begin sel.dst = 1'b1; sel.snd = 1'b1; dec = 1'b1; end
        4'hD: begin sel.dst = 1'b1; sel.snd = 1'b1; end
        4'hE: begin sel.cnd = 1'b1; dec = 1'b1; end
        default: sel.cnd = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pu_target.sv
module pu_target
  import pu_pkg::*;
#(
  parameter int unsigned N_GEN  = 8,
  parameter int unsigned N_ADDR = 4,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        acc_size,
  input  logic              wide32,
  output logic [IDX_W-1:0]  tgt,
  output logic [STEP_W-1:0] step
);
  localparam logic [IDX_W-1:0] ADDR_BASE = IDX_W'(N_GEN);
  localparam logic [IDX_W-1:0] DATA_BASE = IDX_W'(N_GEN + N_ADDR);
  localparam logic [IDX_W-1:0] PAIR_OFS  = IDX_W'(N_ADDR);

  always_comb begin
    if (idx < ADDR_BASE) begin
      tgt  = idx;
      step = STEP_W'(1);
    end else if (idx < DATA_BASE) begin
      tgt  = idx;
      step = wide32 ? STEP_W'(4) : STEP_W'(2);
    end else begin
      // data register: move the paired address register by access size
      tgt = idx - PAIR_OFS;
      unique case (acc_size)
        2'b00:   step = STEP_W'(1);
        2'b01:   step = STEP_W'(2);
        default: step = STEP_W'(4);
      endcase
    end
  end
endmodule

// File: rtl/pu_regfile.sv
module pu_regfile
  import pu_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned N_REGS = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [N_FIELDS-1:0]      en,
  input  logic [IDX_W-1:0]         tgt  [N_FIELDS],
  input  logic [STEP_W-1:0]        step [N_FIELDS],
  input  logic                     dec,
  input  logic                     res_we,
  input  logic [IDX_W-1:0]         res_idx,
  input  logic [XLEN-1:0]          res_data,
  input  logic                     wide32,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [XLEN-1:0]          rd_data,
  output logic [N_REGS*XLEN-1:0]   rf_flat
);
  localparam int unsigned DW   = $clog2(N_FIELDS * 4 + 1);
  localparam int unsigned HALF = XLEN / 2;
  localparam logic [XLEN-1:0] NARROW = {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};

  logic [XLEN-1:0] rf_q [N_REGS];
  logic [XLEN-1:0] wmask;

  assign wmask = wide32 ? {XLEN{1'b1}} : NARROW;

  for (genvar j = 0; j < N_REGS; j++) begin : g_reg
    logic [DW-1:0]   delta;
    logic            hit;
    logic            res_hit;
    logic            wr_en;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] nxt;
    logic [XLEN-1:0] q;

    // next-state: sum every naming that lands here
    always_comb begin
      delta = '0;
      hit   = 1'b0;
      for (int f = 0; f < N_FIELDS; f++) begin
        if (en[f] && (tgt[f] == IDX_W'(j))) begin
          delta = delta + DW'(step[f]);
          hit   = 1'b1;
        end
      end
      res_hit = res_we && (res_idx == IDX_W'(j));
      base    = res_hit ? res_data : q;
      nxt     = (dec ? (base - XLEN'(delta)) : (base + XLEN'(delta))) & wmask;
      wr_en   = commit && (res_hit || hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en) begin
        q <= nxt;
      end
    end

    assign rf_q[j] = q;
    assign rf_flat[j*XLEN +: XLEN] = q;
  end

  assign rd_data = rf_q[rd_idx];
endmodule

// File: rtl/postupd_unit.sv
module postupd_unit
  import pu_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned N_GEN  = 8,
  parameter int unsigned N_ADDR = 4,
  localparam int unsigned N_REGS = N_GEN + 2 * N_ADDR,
  localparam int unsigned IDX_W  = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             imm_form,
  input  logic [3:0]       upd_code,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] snd_idx,
  input  logic [IDX_W-1:0] si4_idx,
  input  logic [IDX_W-1:0] cnd_idx,
  input  logic [1:0]       acc_size,
  input  logic             wide32,
  input  logic             res_we,
  input  logic [XLEN-1:0]  res_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data
);
  fsel_t                 sel;
  logic                  upd_dec;
  logic [N_FIELDS-1:0]   fld_en;
  logic [IDX_W-1:0]      fld_idx  [N_FIELDS];
  logic [IDX_W-1:0]      fld_tgt  [N_FIELDS];
  logic [STEP_W-1:0]     fld_step [N_FIELDS];
  logic [N_REGS*XLEN-1:0] rf_flat;

  pu_decode u_dec (
    .imm_form (imm_form),
    .upd_code (upd_code),
    .sel      (sel),
    .dec      (upd_dec)
  );

  assign fld_en           = sel;
  assign fld_idx[F_DST]   = dst_idx;
  assign fld_idx[F_SND]   = snd_idx;
  assign fld_idx[F_SI4]   = si4_idx;
  assign fld_idx[F_CND]   = cnd_idx;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
    pu_target #(
      .N_GEN  (N_GEN),
      .N_ADDR (N_ADDR),
      .IDX_W  (IDX_W)
    ) u_tgt (
      .idx      (fld_idx[f]),
      .acc_size (acc_size),
      .wide32   (wide32),
      .tgt      (fld_tgt[f]),
      .step     (fld_step[f])
    );
  end

  pu_regfile #(
    .XLEN   (XLEN),
    .N_REGS (N_REGS),
    .IDX_W  (IDX_W)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .en       (fld_en),
    .tgt      (fld_tgt),
    .step     (fld_step),
    .dec      (upd_dec),
    .res_we   (res_we),
    .res_idx  (dst_idx),
    .res_data (res_data),
    .wide32   (wide32),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .rf_flat  (rf_flat)
  );
endmodule

// File: rtl/postupd_unit_chk.sv
module postupd_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned N_GEN  = 8,
  parameter int unsigned N_ADDR = 4,
  parameter int unsigned N_REGS = 16,
  parameter int unsigned IDX_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   commit,
  input logic                   imm_form,
  input logic [3:0]             upd_code,
  input logic [IDX_W-1:0]       dst_idx,
  input logic                   res_we,
  input logic [3:0]             fld_en,
  input logic [N_REGS*XLEN-1:0] rf_flat
);
  localparam int unsigned DATA_LO = (N_GEN + N_ADDR) * XLEN;
  localparam logic [IDX_W-1:0] DATA_BASE = IDX_W'(N_GEN + N_ADDR);

  logic nop_code;
  assign nop_code = imm_form ? (upd_code[1:0] == 2'b00) : (upd_code == 4'h0);

  // R10: nothing moves without the commit strobe
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rf_flat));

  // R1: a selecting-nothing code with no result write leaves the file alone
  p_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !res_we && nop_code) |=> $stable(rf_flat));

  // R3: immediate form updates at most one field, never the short source
  p_imm_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    imm_form |-> ($onehot0(fld_en) && !fld_en[2]));

  // R12: a condition update stands alone
  p_cnd_alone_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fld_en[3] |-> (fld_en[2:0] == 3'b000));

  // R6: data entries only change through a result write
  p_data_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(res_we && (dst_idx >= DATA_BASE)))
      |=> $stable(rf_flat[N_REGS*XLEN-1:DATA_LO]));
endmodule

bind postupd_unit postupd_unit_chk #(
  .XLEN   (XLEN),
  .N_GEN  (N_GEN),
  .N_ADDR (N_ADDR),
  .N_REGS (N_REGS),
  .IDX_W  (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .commit   (commit),
  .imm_form (imm_form),
  .upd_code (upd_code),
  .dst_idx  (dst_idx),
  .res_we   (res_we),
  .fld_en   (fld_en),
  .rf_flat  (rf_flat)
);

// File: tb/postupd_unit_test.sv
module postupd_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;

  typedef struct packed {
    logic        imm;
    logic [3:0]  code;
    logic [3:0]  dst;
    logic [3:0]  snd;
    logic [3:0]  si4;
    logic [3:0]  cnd;
    logic [1:0]  acc;
    logic        w32;
    logic        we;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  // {dec, cnd, si4, snd, dst}
  localparam logic [4:0] RTAB [16] = '{
    5'b0_0000, 5'b0_0111, 5'b1_0100, 5'b0_0100,
    5'b1_0110, 5'b0_0110, 5'b1_0010, 5'b0_0010,
    5'b1_0101, 5'b0_0101, 5'b1_0001, 5'b0_0001,
    5'b1_0011, 5'b0_0011, 5'b1_1000, 5'b0_1000};
  localparam logic [4:0] ITAB [4] = '{5'b0_0000, 5'b0_0010, 5'b0_0001, 5'b1_1000};

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    // preloads with the empty code (R1)
    '{1'b0, 4'h0, 4'd1, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 1'b1, 32'd100,    8'd1},
    '{1'b0, 4'h0, 4'd2, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 1'b1, 32'd200,    8'd1},
    '{1'b0, 4'h0, 4'd3, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 1'b1, 32'd300,    8'd1},
    '{1'b0, 4'h0, 4'd8, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 1'b1, 32'h1000,   8'd1},
    '{1'b0, 4'h0, 4'd9, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 1'b1, 32'h2000,   8'd1},
    '{1'b0, 4'h0, 4'd4, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 1'b1, 32'd50,     8'd1},
    // register-form table (R2, R4)
    '{1'b0, 4'h1, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd2},
    '{1'b0, 4'h2, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd2},
    '{1'b0, 4'h4, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd2},
    '{1'b0, 4'h9, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd4},
    '{1'b0, 4'hC, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd2},
    '{1'b0, 4'hF, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd12},
    '{1'b0, 4'hE, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd2},
    // address register steps (R5)
    '{1'b0, 4'hB, 4'd8, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd5},
    '{1'b0, 4'hB, 4'd8, 4'd2, 4'd3, 4'd4, 2'd0, 1'b0, 1'b0, 32'd0,      8'd5},
    // data register redirect (R6)
    '{1'b0, 4'h7, 4'd1, 4'd13, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,     8'd6},
    '{1'b0, 4'h7, 4'd1, 4'd13, 4'd3, 4'd4, 2'd1, 1'b1, 1'b0, 32'd0,     8'd6},
    '{1'b0, 4'h6, 4'd1, 4'd13, 4'd3, 4'd4, 2'd2, 1'b1, 1'b0, 32'd0,     8'd6},
    // immediate form (R3)
    '{1'b1, 4'hD, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd3},
    '{1'b1, 4'h2, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd3},
    '{1'b1, 4'h7, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd3},
    '{1'b1, 4'hC, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd1},
    // collisions (R7)
    '{1'b0, 4'h1, 4'd3, 4'd3, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,      8'd7},
    '{1'b0, 4'h1, 4'd12, 4'd8, 4'd5, 4'd4, 2'd2, 1'b1, 1'b0, 32'd0,     8'd7},
    // result register update (R8)
    '{1'b0, 4'hB, 4'd6, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b1, 32'h77,     8'd8},
    // wrap (R9)
    '{1'b0, 4'hA, 4'd6, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b1, 32'd0,      8'd9},
    '{1'b0, 4'hB, 4'd6, 4'd2, 4'd3, 4'd4, 2'd0, 1'b0, 1'b1, 32'hABCDFFFF, 8'd9},
    '{1'b0, 4'hA, 4'd7, 4'd2, 4'd3, 4'd4, 2'd0, 1'b0, 1'b1, 32'd0,      8'd9},
    // data entry written by result, then redirected step leaves it (R6)
    '{1'b0, 4'h0, 4'd14, 4'd0, 4'd0, 4'd0, 2'd0, 1'b1, 1'b1, 32'h55,    8'd1},
    '{1'b0, 4'h7, 4'd1, 4'd14, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0,     8'd6}
  };

  logic        clk, rst_n, commit, imm_form, wide32, res_we;
  logic [3:0]  upd_code, dst_idx, snd_idx, si4_idx, cnd_idx, rd_idx;
  logic [1:0]  acc_size;
  logic [31:0] res_data, rd_data;

  logic [31:0] model [NR];
  int n_tests, n_fail;

  postupd_unit uut (
    .clk(clk), .rst_n(rst_n), .commit(commit), .imm_form(imm_form),
    .upd_code(upd_code), .dst_idx(dst_idx), .snd_idx(snd_idx),
    .si4_idx(si4_idx), .cnd_idx(cnd_idx), .acc_size(acc_size),
    .wide32(wide32), .res_we(res_we), .res_data(res_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bstep(logic [3:0] idx, logic [1:0] acc, logic w);
    if (idx < 4'd8) return 1;
    if (idx < 4'd12) return w ? 4 : 2;
    return (acc == 2'd0) ? 1 : (acc == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] btgt(logic [3:0] idx);
    return (idx >= 4'd12) ? idx - 4'd4 : idx;
  endfunction

  task automatic model_apply(vec_t v);
    logic [4:0]  ent;
    logic [3:0]  nm [4];
    logic        touched [NR];
    logic [31:0] nv [NR];
    for (int k = 0; k < NR; k++) begin nv[k] = model[k]; touched[k] = 1'b0; end
    ent = v.imm ? ITAB[v.code[1:0]] : RTAB[v.code];
    nm[0] = v.dst; nm[1] = v.snd; nm[2] = v.si4; nm[3] = v.cnd;
    if (v.we) begin nv[v.dst] = v.data; touched[v.dst] = 1'b1; end
    for (int f = 0; f < 4; f++) begin
      if (ent[f]) begin
        logic [3:0] t;
        t = btgt(nm[f]);
        touched[t] = 1'b1;
        if (ent[4]) nv[t] = nv[t] - 32'(bstep(nm[f], v.acc, v.w32));
        else        nv[t] = nv[t] + 32'(bstep(nm[f], v.acc, v.w32));
      end
    end
    for (int k = 0; k < NR; k++) begin
      if (touched[k] && !v.w32) nv[k] = nv[k] & 32'h0000FFFF;
      model[k] = nv[k];
    end
  endtask

  task automatic check_all(int req);
    logic bad;
    bad = 1'b0;
    n_tests++;
    for (int k = 0; k < NR; k++) begin
      rd_idx = 4'(k);
      #1;
      if (!bad && rd_data !== model[k]) begin
        bad = 1'b1;
        n_fail++;
        $display("FAIL R%0d entry %0d actual %h expected %h", req, k, rd_data, model[k]);
      end
    end
  endtask

  task automatic drive(vec_t v, logic c);
    @(negedge clk);
    commit = c; imm_form = v.imm; upd_code = v.code; dst_idx = v.dst;
    snd_idx = v.snd; si4_idx = v.si4; cnd_idx = v.cnd; acc_size = v.acc;
    wide32 = v.w32; res_we = v.we; res_data = v.data;
    @(posedge clk);
    #1;
    commit = 1'b0;
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    commit = 0; imm_form = 0; upd_code = 0; dst_idx = 0; snd_idx = 0;
    si4_idx = 0; cnd_idx = 0; acc_size = 0; wide32 = 1; res_we = 0;
    res_data = 0; rd_idx = 0;
    rst_n = 1'b0;
    for (int k = 0; k < NR; k++) model[k] = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all(11);  // R11 reset state

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 1'b1);
      model_apply(VEC[i]);
      check_all(int'(VEC[i].req));
    end

    // R10: full triple update and result write, but no commit
    drive('{1'b0, 4'h1, 4'd1, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b1, 32'hDEAD, 8'd10}, 1'b0);
    check_all(10);
    repeat (2) @(posedge clk);
    check_all(10);

    // R11: reset mid-run clears everything
    @(negedge clk) rst_n = 1'b0;
    #1;
    for (int k = 0; k < NR; k++) model[k] = 32'd0;
    check_all(11);
    @(negedge clk) rst_n = 1'b1;

    // R9: 32-bit decrement of zero wraps to all ones
    drive('{1'b0, 4'hA, 4'd5, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0, 8'd9}, 1'b1);
    model_apply('{1'b0, 4'hA, 4'd5, 4'd2, 4'd3, 4'd4, 2'd0, 1'b1, 1'b0, 32'd0, 8'd9});
    check_all(9);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule